// File: doc/BRIEF.md
# Electroluminescent Panel Drive Sequencer

This block drives the two clock lines of an electroluminescent panel boost stage: a pump clock that switches the inductor transistor and a polarity clock that switches the panel discharge transistor. Each line has its own clock source and duty cycle. Both are chosen from one 9-bit configuration word `cfg`. A free-running prescaler inside the block supplies the slow taps. The block's own clock serves as the high-speed base clock.

A one-cycle `light_on` pulse starts the pump clock first. The polarity clock joins only after the pump has taken its first step. A one-cycle `light_off` pulse does not cut the outputs at once. The block keeps both clocks running until the pump clock finishes its current high interval, and then drives both low, so no charge is left stranded on the panel.

The controller has four states:

- `ST_IDLE`: both outputs low.
- `ST_PUMP`: the pump runs alone.
- `ST_RUN`: both clocks run.
- `ST_DRAIN`: an off request is waiting for the pump's falling edge.

The transitions are:

- IDLE→PUMP on `light_on`.
- PUMP→DRAIN on `light_off`. This takes priority over the pump tick.
- PUMP→RUN on a pump tick.
- RUN→DRAIN on `light_off`.
- DRAIN→IDLE on a pump tick that ends a high pump phase.

Top module: `el_drive_seq`

## Requirements
- R1: During and after reset both outputs are low, the controller is idle, and the prescaler count is 0.
- R2: `light_on` sampled in idle makes `pump_clk` high from the next cycle. `pol_clk` stays low until the first pump tick has been taken, and is never high in idle.
- R3: The prescaler increments by one every clock. A tap k ticks in the cycle where the prescaler's bits k..0 equal 1 followed by k zeros. `cfg[3:2]` selects the pump tap: 11 selects tap 5, 10 tap 6, 01 tap 7, 00 tap 8.
- R4: Duty codes (`cfg[1:0]` for the pump, `cfg[5:4]` for the polarity clock) work as follows:
    - 11 holds the output high.
    - 10, 01 and 00 give a period of 2, 3 and 4 ticks respectively, with the output high for the first tick-period only.
    - The phase starts at 0, which is high.
- R5: `cfg[8]` selects the polarity source. 1 gives a tick every clock. 0 gives tap 0, a tick whenever prescaler bit 0 is 1.
- R6: `cfg[7:6]` divide the polarity source before the duty stage: 11 divides by 8, 10 by 4, 01 by 2, 00 by 1. The divider and phase restart when the polarity clock is enabled.
- R7: After `light_off` in the pump-only or running state, both clocks keep running. On the next pump tick taken while the pump output is high, both outputs go low in the following cycle.
- R8: `light_off` in idle, and `light_on` outside idle, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the high-speed base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 9 | Source, divide and duty configuration word |
| light_on | input | 1 | One-cycle request to start the panel |
| light_off | input | 1 | One-cycle request to stop the panel |
| pump_clk | output | 1 | Pump (boost) clock |
| pol_clk | output | 1 | Polarity (discharge) clock |

## Verification
The bench runs random configurations and on/off timings against a cycle model, and adds directed cases.

The hardest corner is the off request arriving while the pump output is low. A design that stopped at once, or at the wrong tick, would cut the pump mid-cycle and leave the panel charged. The bench therefore checks every cycle of the drain interval, including the held-high pump code, where the drain must end at the very next pump tick.

Other cases target the following errors:

- Polarity starting in the same cycle as the pump: caught by checking the first cycles after `light_on`.
- Swapped tap or divider encodings: these shift the tick positions, and the per-cycle comparison exposes the wrong edges.
- Stray commands: an off in idle, or an on during a run, are checked to leave the output pattern unchanged.

// File: rtl/el_seq_pkg.sv
package el_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PUMP  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } el_state_e;

    localparam int CFG_W   = 9;
    localparam int PHASE_W = 2;

    // duty code -> period in ticks (11 -> 1 means held high)
    function automatic logic [2:0] duty_period(input logic [1:0] code);
        case (code)
            2'b11:   return 3'd1;
            2'b10:   return 3'd2;
            2'b01:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    // divide code -> divisor
    function automatic logic [3:0] div_ratio(input logic [1:0] code);
        case (code)
            2'b11:   return 4'd8;
            2'b10:   return 4'd4;
            2'b01:   return 4'd2;
            default: return 4'd1;
        endcase
    endfunction
endpackage

// File: rtl/el_prescaler.sv
module el_prescaler #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    a_r3_prescaler_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/el_pol_div.sv
module el_pol_div
    import el_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       src_tick,
    input  logic [1:0] code,
    output logic       adv
);
    logic [3:0] ratio;
    logic [2:0] cnt;

    always_comb begin
        ratio = div_ratio(code);
        adv   = src_tick && ({1'b0, cnt} >= ratio - 4'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (src_tick) cnt <= adv ? 3'd0 : cnt + 3'd1;
    end

    a_r6_no_advance_when_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) && code == 2'b11 |-> !adv);
endmodule

// File: rtl/el_duty_gen.sv
module el_duty_gen
    import el_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [1:0] code,
    output logic       hi
);
    logic [PHASE_W-1:0] phase;
    logic [2:0]         period;

    always_comb begin
        period = duty_period(code);
        hi     = (phase == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   phase <= '0;
        else if (clr) phase <= '0;
        else if (adv) phase <= ({1'b0, phase} >= period - 3'd1) ? '0 : phase + 1'b1;
    end

    a_r4_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
        code == 2'b11 && $past(code) == 2'b11 && $past(code, 2) == 2'b11 |-> hi);
endmodule

// File: rtl/el_drive_seq.sv
module el_drive_seq
    import el_seq_pkg::*;
#(
    parameter int PUMP_TAP_BASE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             light_on,
    input  logic             light_off,
    output logic             pump_clk,
    output logic             pol_clk
);
    localparam int PRE_W = PUMP_TAP_BASE + 4;

    el_state_e        st, st_nx;
    logic [PRE_W-1:0] pre_cnt;
    logic [3:0]       tap_tick;
    logic             pump_tick, pol_src, pol_adv;
    logic             pump_hi, pol_hi;
    logic             pump_clr, pol_clr, pump_adv;

    el_prescaler #(.W(PRE_W)) u_pre (.clk(clk), .rst_n(rst_n), .cnt(pre_cnt));

    // tap tick per select code: code 3 -> base tap, code 0 -> base+3
    for (genvar gi = 0; gi < 4; gi++) begin : g_tap
        localparam int TAP = PUMP_TAP_BASE + 3 - gi;
        localparam logic [PRE_W-1:0] MASK = PRE_W'((64'd2 << TAP) - 64'd1);
        localparam logic [PRE_W-1:0] HIT  = PRE_W'(64'd1 << TAP);
        assign tap_tick[gi] = ((pre_cnt & MASK) == HIT);
    end

    always_comb begin
        pump_tick = tap_tick[cfg[3:2]];
        pol_src   = cfg[8] ? 1'b1 : pre_cnt[0];
        pump_clr  = (st == ST_IDLE);
        pump_adv  = pump_tick && (st != ST_IDLE);
        pol_clr   = !(st == ST_RUN || st == ST_DRAIN);
    end

    el_pol_div u_pdiv (
        .clk(clk), .rst_n(rst_n), .clr(pol_clr),
        .src_tick(pol_src), .code(cfg[7:6]), .adv(pol_adv)
    );

    el_duty_gen u_pump_duty (
        .clk(clk), .rst_n(rst_n), .clr(pump_clr),
        .adv(pump_adv), .code(cfg[1:0]), .hi(pump_hi)
    );

    el_duty_gen u_pol_duty (
        .clk(clk), .rst_n(rst_n), .clr(pol_clr),
        .adv(pol_adv), .code(cfg[5:4]), .hi(pol_hi)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (light_on) st_nx = ST_PUMP;
            ST_PUMP:  if (light_off) st_nx = ST_DRAIN;
                      else if (pump_tick) st_nx = ST_RUN;
            ST_RUN:   if (light_off) st_nx = ST_DRAIN;
            ST_DRAIN: if (pump_tick && pump_hi) st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        pump_clk = (st != ST_IDLE) && pump_hi;
        pol_clk  = (st == ST_RUN || st == ST_DRAIN) && pol_hi;
    end

    a_r2_pol_after_pump: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pol_clk) |-> $past(st) != ST_IDLE);
    a_r7_stop_at_pump_fall: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && $past(st) == ST_DRAIN |-> $past(pump_clk));
    a_r8_idle_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && light_off && !light_on |=> st == ST_IDLE && !pump_clk);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st) == ST_IDLE && st == ST_IDLE |-> !pol_clk && !pump_clk);
endmodule

// File: tb/el_drive_seq_bench.sv
module el_drive_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cfg = '0;
    logic       light_on = 1'b0, light_off = 1'b0;
    logic       pump_clk, pol_clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int m_pre, m_st, m_pph, m_qph, m_div;

    always #2 clk = ~clk;

    el_drive_seq u_el_drive_seq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .light_on(light_on), .light_off(light_off),
        .pump_clk(pump_clk), .pol_clk(pol_clk)
    );

    function automatic int f_period(input logic [1:0] c);
        return (c == 2'b11) ? 1 : (c == 2'b10) ? 2 : (c == 2'b01) ? 3 : 4;
    endfunction
    function automatic int f_ratio(input logic [1:0] c);
        return (c == 2'b11) ? 8 : (c == 2'b10) ? 4 : (c == 2'b01) ? 2 : 1;
    endfunction
    function automatic bit f_tick(input int pre, input int k);
        return (pre % (2 << k)) == (1 << k);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_st = 0; m_pph = 0; m_qph = 0; m_div = 0;
        end else begin
            int tap, pp, qp, rt, nst;
            bit pt, src, padv;
            tap  = 8 - int'(cfg[3:2]);
            pt   = f_tick(m_pre, tap);
            pp   = f_period(cfg[1:0]);
            qp   = f_period(cfg[5:4]);
            rt   = f_ratio(cfg[7:6]);
            src  = cfg[8] ? 1'b1 : (m_pre % 2 == 1);
            padv = src && (m_div >= rt - 1);
            nst  = m_st;
            case (m_st)
                0: if (light_on) nst = 1;
                1: if (light_off) nst = 3; else if (pt) nst = 2;
                2: if (light_off) nst = 3;
                default: if (pt && m_pph == 0) nst = 0;
            endcase
            if (m_st == 0) m_pph = 0;
            else if (pt) m_pph = (m_pph >= pp - 1) ? 0 : m_pph + 1;
            if (m_st == 2 || m_st == 3) begin
                if (src) m_div = padv ? 0 : m_div + 1;
                if (padv) m_qph = (m_qph >= qp - 1) ? 0 : m_qph + 1;
            end else begin
                m_div = 0; m_qph = 0;
            end
            m_st = nst;
            m_pre = (m_pre + 1) % 512;
        end
    end

    task automatic check(input string t, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", t, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, "pump_clk", pump_clk, (m_st != 0) && (m_pph == 0));
            check(tag, "pol_clk", pol_clk, (m_st == 2 || m_st == 3) && (m_qph == 0));
        end
    end

    task automatic pulse_on();
        @(negedge clk); light_on = 1'b1; @(negedge clk); light_on = 1'b0;
    endtask
    task automatic pulse_off();
        @(negedge clk); light_off = 1'b1; @(negedge clk); light_off = 1'b0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 6000 && m_st != 0; i++) @(negedge clk);
        check("R7", "drain finished", m_st == 0, 1'b1);
    endtask

    task automatic session(input logic [8:0] c, input int run, input string t);
        cfg = c; tag = t;
        pulse_on();
        repeat (run) @(negedge clk);
        pulse_off();
        wait_idle();
        check("R7", "pump low after drain", pump_clk, 1'b0);
        check("R7", "pol low after drain", pol_clk, 1'b0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED);
        #1;
        check("R1", "pump in reset", pump_clk, 1'b0);
        check("R1", "pol in reset", pol_clk, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "pump after reset", pump_clk, 1'b0);
        check("R1", "pol after reset", pol_clk, 1'b0);

        // R8: off in idle has no effect
        tag = "R8";
        pulse_off();
        repeat (3) @(negedge clk);
        check("R8", "pump idle after stray off", pump_clk, 1'b0);

        // R2: pump first, polarity held low
        cfg = 9'b1_00_00_11_00; tag = "R2";
        @(negedge clk); light_on = 1'b1; @(negedge clk); light_on = 1'b0;
        check("R2", "pump high after on", pump_clk, 1'b1);
        check("R2", "pol low after on", pol_clk, 1'b0);
        repeat (400) @(negedge clk);
        tag = "R8";
        pulse_on();
        repeat (300) @(negedge clk);
        pulse_off();
        wait_idle();

        session(9'b0_00_00_00_00, 2500, "R3");
        session(9'b1_00_10_01_01, 1500, "R3");
        session(9'b1_00_11_10_11, 700,  "R4");
        session(9'b1_00_01_11_10, 900,  "R4");
        session(9'b0_00_10_11_00, 600,  "R5");
        session(9'b1_11_00_11_11, 600,  "R6");
        session(9'b0_10_01_11_10, 800,  "R6");
        session(9'b1_01_00_00_11, 37,   "R7");

        for (int s = 0; s < 24; s++) begin
            logic [8:0] rc;
            int run;
            rc  = 9'($urandom());
            run = 20 + int'($urandom() % 2500);
            session(rc, run, "R4");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule